// File: doc/BRIEF.md
# Two-Device Cascade Result Merger

This block sits at the result side of a ternary search device that can be chained with one other device, so that the pair behaves as one table twice the size. Every search yields a local result, made of a valid strobe, a match flag and a 20-bit entry index. The neighbouring device delivers its own result for the same search on a set of cascade inputs, together with one even-parity bit that covers its index. The merger picks one winner from the two results and presents a single combined result. The combined index is one bit wider than a device index. Its extra top bit names the device that holds the winning entry.

Priority depends only on position in the chain. A one-bit device ID input sets that position. The device with ID 0 always outranks the device with ID 1. So when the ID is 0 the local result has priority, and when the ID is 1 the cascade result has priority. The two results must arrive in the same clock cycle. The merge decision and a fixed delay line add a constant number of cycles (8 by default) to the base search latency. Two side checks run alongside: a sticky flag for cascade index parity errors, and a one-cycle flag for strobes that arrive in different cycles.

Top module: `cascade_merge`

## Requirements
- R1: While reset is held, and right after it, outValid, outMatch, outIndex, parityErr and protoErr are all 0.
- R2: When locValid and casValid are both high in the same cycle, outValid is high for exactly one cycle, on the 8th rising edge (MERGE_LAT) after the edge that samples them. Results on consecutive cycles come out on consecutive cycles.
- R3: With devId = 0 and locMatch = 1, outMatch = 1 and outIndex = {1'b0, locIndex}, whatever the cascade result is.
- R4: With devId = 1 and casMatch = 1, outMatch = 1 and outIndex = {1'b0, casIndex}, whatever the local result is.
- R5: When only the lower-priority side matched, its index is output and outIndex[20] holds that device's ID: 1 for the cascade side when devId = 0, and 1 for the local side when devId = 1.
- R6: When neither side matched, the result cycle shows outValid = 1, outMatch = 0 and outIndex = 0. Whenever outValid = 0, outMatch and outIndex are 0.
- R7: casParity is correct when the XOR of casIndex and casParity is 0 (even parity). A wrong parity bit with casValid high sets parityErr from the next edge, and it stays set until reset. A wrong parity bit with casValid low has no effect.
- R8: If exactly one of locValid and casValid is high, protoErr is high for the one cycle after that edge and no result is produced (outValid stays 0 in the slot). protoErr is 0 in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| devId | input | 1 | Position in the chain; 0 is the higher-priority device |
| locValid | input | 1 | Local result strobe |
| locMatch | input | 1 | Local search hit |
| locIndex | input | 20 | Local hit entry index |
| casValid | input | 1 | Cascade result strobe from the neighbouring device |
| casMatch | input | 1 | Cascade search hit |
| casIndex | input | 20 | Cascade hit entry index |
| casParity | input | 1 | Even-parity bit over casIndex |
| outValid | output | 1 | Merged result strobe |
| outMatch | output | 1 | Merged hit flag |
| outIndex | output | 21 | Winning index; bit 20 is the winning device's ID |
| parityErr | output | 1 | Sticky cascade parity error |
| protoErr | output | 1 | One-cycle strobe misalignment flag |

## Verification
The properties assume that devId stays constant while results are in flight. The bench changes devId only together with a new vector, after the previous result has left the delay line. The latency property assumes that any cycle in which both strobes are high is a genuine search result. The bench therefore holds both strobes low between vectors, except in the back-to-back case, where it drives two adjacent results on purpose. Misaligned strobes and corrupted parity appear only in directed vectors meant to provoke the two error flags. All other stimulus carries correct parity.

// File: rtl/cascade_merge_pkg.sv
package cascade_merge_pkg;

  // Strobes handed from the control unit to the datapath each cycle.
  typedef struct packed {
    logic capture;    // both sides presented a result this cycle
    logic localHigh;  // local result outranks the cascade result
  } mergeStrobe_t;

endpackage

// File: rtl/cascade_merge_ctrl.sv
module cascade_merge_ctrl
  import cascade_merge_pkg::*;
#(
  parameter int IDX_W = 20
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             devId,
  input  logic             locValid,
  input  logic             casValid,
  input  logic [IDX_W-1:0] casIndex,
  input  logic             casParity,
  output mergeStrobe_t     strobe,
  output logic             parityErr,
  output logic             protoErr
);

  logic parityBad;
  logic misaligned;

  // Even parity: index bits plus parity bit must XOR to zero.
  assign parityBad  = casValid & (^{casIndex, casParity});
  assign misaligned = locValid ^ casValid;

  always_comb begin
    strobe.capture   = locValid & casValid;
    strobe.localHigh = ~devId;   // device 0 always outranks device 1
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      parityErr <= 1'b0;
      protoErr  <= 1'b0;
    end else begin
      parityErr <= parityErr | parityBad;
      protoErr  <= misaligned;
    end
  end

endmodule

// File: rtl/cascade_merge_dp.sv
module cascade_merge_dp
  import cascade_merge_pkg::*;
#(
  parameter int IDX_W     = 20,
  parameter int MERGE_LAT = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  mergeStrobe_t     strobe,
  input  logic             devId,
  input  logic             locMatch,
  input  logic [IDX_W-1:0] locIndex,
  input  logic             casMatch,
  input  logic [IDX_W-1:0] casIndex,
  output logic             outValid,
  output logic             outMatch,
  output logic [IDX_W:0]   outIndex
);

  localparam int OUT_W = IDX_W + 1;

  logic             hiMatch, loMatch;
  logic [IDX_W-1:0] hiIndex, loIndex;
  logic             hiDev, loDev;
  logic             selMatch;
  logic [OUT_W-1:0] selIndex;

  // Order the two results by chain position.
  always_comb begin
    if (strobe.localHigh) begin
      hiMatch = locMatch;  hiIndex = locIndex;  hiDev = devId;
      loMatch = casMatch;  loIndex = casIndex;  loDev = ~devId;
    end else begin
      hiMatch = casMatch;  hiIndex = casIndex;  hiDev = ~devId;
      loMatch = locMatch;  loIndex = locIndex;  loDev = devId;
    end
  end

  always_comb begin
    selMatch = 1'b0;
    selIndex = '0;
    if (strobe.capture) begin
      if (hiMatch) begin
        selMatch = 1'b1;
        selIndex = {hiDev, hiIndex};
      end else if (loMatch) begin
        selMatch = 1'b1;
        selIndex = {loDev, loIndex};
      end
    end
  end

  // Fixed-depth delay line carrying the decided result.
  logic [MERGE_LAT-1:0] vPipe;
  logic [MERGE_LAT-1:0] mPipe;
  logic [OUT_W-1:0]     iPipe [MERGE_LAT];

  generate
    for (genvar s = 0; s < MERGE_LAT; s++) begin : g_stage
      if (s == 0) begin : g_head
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            vPipe[0] <= 1'b0;
            mPipe[0] <= 1'b0;
            iPipe[0] <= '0;
          end else begin
            vPipe[0] <= strobe.capture;
            mPipe[0] <= selMatch;
            iPipe[0] <= selIndex;
          end
        end
      end else begin : g_body
        always_ff @(posedge clk or negedge rstN) begin
          if (!rstN) begin
            vPipe[s] <= 1'b0;
            mPipe[s] <= 1'b0;
            iPipe[s] <= '0;
          end else begin
            vPipe[s] <= vPipe[s-1];
            mPipe[s] <= mPipe[s-1];
            iPipe[s] <= iPipe[s-1];
          end
        end
      end
    end
  endgenerate

  assign outValid = vPipe[MERGE_LAT-1];
  assign outMatch = mPipe[MERGE_LAT-1];
  assign outIndex = iPipe[MERGE_LAT-1];

endmodule

// File: rtl/cascade_merge.sv
module cascade_merge
  import cascade_merge_pkg::*;
#(
  parameter int IDX_W     = 20,
  parameter int MERGE_LAT = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             devId,
  input  logic             locValid,
  input  logic             locMatch,
  input  logic [IDX_W-1:0] locIndex,
  input  logic             casValid,
  input  logic             casMatch,
  input  logic [IDX_W-1:0] casIndex,
  input  logic             casParity,
  output logic             outValid,
  output logic             outMatch,
  output logic [IDX_W:0]   outIndex,
  output logic             parityErr,
  output logic             protoErr
);

  mergeStrobe_t strobe;

  cascade_merge_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .devId     (devId),
    .locValid  (locValid),
    .casValid  (casValid),
    .casIndex  (casIndex),
    .casParity (casParity),
    .strobe    (strobe),
    .parityErr (parityErr),
    .protoErr  (protoErr)
  );

  cascade_merge_dp #(.IDX_W(IDX_W), .MERGE_LAT(MERGE_LAT)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .devId    (devId),
    .locMatch (locMatch),
    .locIndex (locIndex),
    .casMatch (casMatch),
    .casIndex (casIndex),
    .outValid (outValid),
    .outMatch (outMatch),
    .outIndex (outIndex)
  );

endmodule

// File: rtl/cascade_merge_checker.sv
module cascade_merge_checker #(
  parameter int IDX_W     = 20,
  parameter int MERGE_LAT = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             locValid,
  input logic             casValid,
  input logic [IDX_W-1:0] casIndex,
  input logic             casParity,
  input logic             outValid,
  input logic             outMatch,
  input logic [IDX_W:0]   outIndex,
  input logic             parityErr,
  input logic             protoErr
);

  // Independent model of when a merged result is due.
  logic [MERGE_LAT-1:0] dueLine;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dueLine <= '0;
    end else begin
      dueLine[0] <= locValid & casValid;
      for (int k = 1; k < MERGE_LAT; k++) dueLine[k] <= dueLine[k-1];
    end
  end

  p_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    outValid == dueLine[MERGE_LAT-1]);

  p_idle_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> (!outMatch && outIndex == '0));

  p_parity_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    parityErr |=> parityErr);

  p_parity_catch_r7: assert property (@(posedge clk) disable iff (!rstN)
    (casValid && (^{casIndex, casParity})) |=> parityErr);

  p_proto_flag_r8: assert property (@(posedge clk) disable iff (!rstN)
    (locValid != casValid) |=> protoErr);

  p_proto_clear_r8: assert property (@(posedge clk) disable iff (!rstN)
    (locValid == casValid) |=> !protoErr);

endmodule

bind cascade_merge cascade_merge_checker #(
  .IDX_W     (IDX_W),
  .MERGE_LAT (MERGE_LAT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .locValid  (locValid),
  .casValid  (casValid),
  .casIndex  (casIndex),
  .casParity (casParity),
  .outValid  (outValid),
  .outMatch  (outMatch),
  .outIndex  (outIndex),
  .parityErr (parityErr),
  .protoErr  (protoErr)
);

// File: tb/cascade_merge_bench.sv
module cascade_merge_bench;

  localparam int IW  = 20;
  localparam int LAT = 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic          devId;
  logic          locValid, locMatch;
  logic [IW-1:0] locIndex;
  logic          casValid, casMatch;
  logic [IW-1:0] casIndex;
  logic          casParity;
  logic          outValid, outMatch;
  logic [IW:0]   outIndex;
  logic          parityErr, protoErr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;   // 250 MHz

  cascade_merge #(.IDX_W(IW), .MERGE_LAT(LAT)) u_cascade_merge (
    .clk(clk), .rstN(rstN), .devId(devId),
    .locValid(locValid), .locMatch(locMatch), .locIndex(locIndex),
    .casValid(casValid), .casMatch(casMatch), .casIndex(casIndex),
    .casParity(casParity),
    .outValid(outValid), .outMatch(outMatch), .outIndex(outIndex),
    .parityErr(parityErr), .protoErr(protoErr)
  );

  typedef struct packed {
    logic          dev;
    logic          lv;
    logic          lm;
    logic [IW-1:0] li;
    logic          cv;
    logic          cm;
    logic [IW-1:0] ci;
    logic          eV;
    logic          eM;
    logic [IW:0]   eI;
    logic          eP;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b1,20'h12345,1'b1,1'b1,20'h0ABCD,1'b1,1'b1,21'h012345,1'b0}, // R3
    '{1'b0,1'b1,1'b0,20'h11111,1'b1,1'b1,20'h54321,1'b1,1'b1,21'h154321,1'b0}, // R5
    '{1'b1,1'b1,1'b1,20'h0F0F0,1'b1,1'b1,20'hAAAAA,1'b1,1'b1,21'h0AAAAA,1'b0}, // R4
    '{1'b1,1'b1,1'b1,20'h0F0F0,1'b1,1'b0,20'h33333,1'b1,1'b1,21'h10F0F0,1'b0}, // R5
    '{1'b0,1'b1,1'b0,20'h77777,1'b1,1'b0,20'h88888,1'b1,1'b0,21'h000000,1'b0}, // R6
    '{1'b1,1'b1,1'b0,20'h77777,1'b1,1'b0,20'h88888,1'b1,1'b0,21'h000000,1'b0}, // R6
    '{1'b0,1'b1,1'b1,20'h00042,1'b0,1'b0,20'h00000,1'b0,1'b0,21'h000000,1'b1}, // R8
    '{1'b1,1'b0,1'b0,20'h00000,1'b1,1'b1,20'h00001,1'b0,1'b0,21'h000000,1'b1}, // R8
    '{1'b0,1'b1,1'b1,20'hFFFFF,1'b1,1'b1,20'h00000,1'b1,1'b1,21'h0FFFFF,1'b0}  // R3
  };

  function automatic string reqOf(int i);
    case (i)
      0, 8:    return "R3";
      2:       return "R4";
      1, 3:    return "R5";
      4, 5:    return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    locValid = 0; locMatch = 0; locIndex = '0;
    casValid = 0; casMatch = 0; casIndex = '0; casParity = 0;
  endtask

  task automatic driveVec(vec_t v);
    devId    = v.dev;
    locValid = v.lv; locMatch = v.lm; locIndex = v.li;
    casValid = v.cv; casMatch = v.cm; casIndex = v.ci;
    casParity = ^v.ci;
  endtask

  task automatic chkResult(string req, vec_t v);
    chk(req, "outValid", {31'b0, outValid}, {31'b0, v.eV});
    chk(req, "outMatch", {31'b0, outMatch}, {31'b0, v.eM});
    chk(req, "outIndex", {11'b0, outIndex}, {11'b0, v.eI});
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    devId = 0;
    idle();
    rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: reset state
    chk("R1", "outValid",  {31'b0, outValid},  0);
    chk("R1", "outMatch",  {31'b0, outMatch},  0);
    chk("R1", "outIndex",  {11'b0, outIndex},  0);
    chk("R1", "parityErr", {31'b0, parityErr}, 0);
    chk("R1", "protoErr",  {31'b0, protoErr},  0);
    rstN = 1;
    repeat (2) @(negedge clk);

    // Table walk: one vector, then idle until its slot.
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      driveVec(VEC[i]);
      @(posedge clk);
      @(negedge clk);
      chk(reqOf(i), "protoErr", {31'b0, protoErr}, {31'b0, VEC[i].eP});
      idle();
      repeat (LAT - 1) @(posedge clk);
      @(negedge clk);
      chkResult(reqOf(i), VEC[i]);
      chk("R7", "parityErr clean", {31'b0, parityErr}, 0);
    end

    // R2: exact latency and back-to-back results.
    @(negedge clk);
    driveVec(VEC[0]);
    @(posedge clk);
    @(negedge clk);
    driveVec(VEC[3]);
    @(posedge clk);
    @(negedge clk);
    idle();
    repeat (5) @(posedge clk);
    @(negedge clk);
    chk("R2", "outValid early", {31'b0, outValid}, 0);
    @(posedge clk); @(negedge clk);
    chkResult("R2", VEC[0]);
    @(posedge clk); @(negedge clk);
    chkResult("R2", VEC[3]);
    @(posedge clk); @(negedge clk);
    chk("R2", "outValid single", {31'b0, outValid}, 0);

    // R7: bad parity without casValid is ignored.
    @(negedge clk);
    casIndex = 20'h00003; casParity = 1'b1; casValid = 0;
    @(posedge clk); @(negedge clk);
    chk("R7", "parityErr ignored", {31'b0, parityErr}, 0);
    idle();

    // R7: bad parity with casValid sets a sticky flag.
    @(negedge clk);
    driveVec(VEC[0]);
    casParity = ~(^VEC[0].ci);
    @(posedge clk); @(negedge clk);
    chk("R7", "parityErr set", {31'b0, parityErr}, 1);
    idle();
    repeat (4) @(posedge clk);
    @(negedge clk);
    driveVec(VEC[2]);
    @(posedge clk); @(negedge clk);
    idle();
    chk("R7", "parityErr sticky", {31'b0, parityErr}, 1);

    // R1: reset clears the sticky flag and the delay line.
    rstN = 0;
    @(negedge clk);
    chk("R1", "parityErr reset", {31'b0, parityErr}, 0);
    chk("R1", "outValid reset",  {31'b0, outValid},  0);
    rstN = 1;
    repeat (LAT + 1) @(posedge clk);
    @(negedge clk);
    chk("R1", "outValid after reset", {31'b0, outValid}, 0);

    done = 1;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule